// File: doc/BRIEF.md
# Self-Test Incrementing Pattern Source

This block feeds the transmit path of a serial link with a known character stream for built-in self-test. The characters leave it before line coding. It emits one character per transmit clock as an 8-bit value with a control-character flag beside it. A third output marks the clock cycles in which the stream is live.

When the test-enable input rises, the block first sends a short burst of comma characters (K28.5). This lets the receive side re-center its elastic buffers. It then loops without end over a frame made of an up-counting data byte sequence and a run of K28.5 idle characters. A receiver that knows this frame can check it byte by byte. When test-enable falls, the block stops and returns to its quiet state. The next enable starts again from the comma burst.

Top module: `selftest_pattern_gen`

## Requirements
- R1: A synchronous active-high `rst` sampled at a clock edge forces the outputs after that edge to `active_o`=0, `kflag_o`=0, `char_o`=0x00.
- R2: While `active_o` is 0, `char_o` is 0x00 and `kflag_o` is 0. `active_o` stays 0 for as long as `test_en` is sampled low.
- R3: When `test_en` is first sampled high at an edge, the output from that edge on is a burst of exactly 16 characters of value 0xBC with `kflag_o`=1. It comes before any data byte.
- R4: After the comma burst, the data bytes run 0x00, 0x01, … 0xFF, one per clock, with `kflag_o`=0.
- R5: Each 0xFF data byte is followed by exactly three idle characters (0xBC, `kflag_o`=1). The data count then restarts at 0x00, and this frame repeats for as long as `test_en` stays high.
- R6: `kflag_o` is 1 only on comma-burst and idle characters, and every character with `kflag_o`=1 carries 0xBC.
- R7: `test_en` sampled low at an edge makes `active_o` 0 after that edge. A later enable restarts with the full 16-character comma burst, not from where the stream stopped.
- R8: While enabled, `active_o` stays 1 on every clock, with no gap between the burst, the data and the idle characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit character clock |
| rst | input | 1 | Synchronous active-high reset |
| test_en | input | 1 | Self-test enable; high runs the pattern |
| char_o | output | 8 | Character before line coding |
| kflag_o | output | 1 | High when `char_o` is a control character |
| active_o | output | 1 | High while a test character is being emitted |

## Verification
The hardest case to reach from the ports is the frame boundary in steady state. That is the step from the byte 0xFF through the three idles and back to 0x00, and it first occurs about 270 clocks after enable. The stimulus holds the enable high through two complete frames so that the boundary is crossed twice. The other hard case is an enable dropped in the middle of a frame and raised again. The stimulus does this during the data run and again during the comma burst, and then checks that the stream restarts with a complete burst rather than resuming.

// File: rtl/selftest_pkg.sv
package selftest_pkg;

   typedef enum logic [1:0] {
      PH_OFF  = 2'd0,
      PH_SYNC = 2'd1,
      PH_DATA = 2'd2,
      PH_IDLE = 2'd3
   } phase_e;

   localparam logic [7:0] COMMA_K28_5 = 8'hBC;

endpackage

// File: rtl/bist_phase_seq.sv
module bist_phase_seq
   import selftest_pkg::*;
#(
   parameter int SYNC_LEN  = 16,
   parameter int FRAME_LEN = 256,
   parameter int IDLE_LEN  = 3,
   parameter int CNT_W     = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             enable,
   output phase_e           phase_o,
   output logic [CNT_W-1:0] cnt_o
);

   localparam logic [CNT_W-1:0] SYNC_LAST  = CNT_W'(SYNC_LEN - 1);
   localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_LEN - 1);
   localparam logic [CNT_W-1:0] IDLE_LAST  = CNT_W'(IDLE_LEN - 1);

   phase_e           phase_q, phase_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             at_end;

   always_comb begin
      unique case (phase_q)
         PH_SYNC: at_end = (cnt_q == SYNC_LAST);
         PH_DATA: at_end = (cnt_q == FRAME_LAST);
         PH_IDLE: at_end = (cnt_q == IDLE_LAST);
         default: at_end = 1'b0;
      endcase
   end

   always_comb begin
      phase_d = phase_q;
      cnt_d   = cnt_q + 1'b1;
      if (!enable) begin
         phase_d = PH_OFF;
         cnt_d   = '0;
      end else begin
         unique case (phase_q)
            PH_OFF: begin
               phase_d = PH_SYNC;
               cnt_d   = '0;
            end
            PH_SYNC: if (at_end) begin
               phase_d = PH_DATA;
               cnt_d   = '0;
            end
            PH_DATA: if (at_end) begin
               phase_d = PH_IDLE;
               cnt_d   = '0;
            end
            PH_IDLE: if (at_end) begin
               phase_d = PH_DATA;
               cnt_d   = '0;
            end
            default: begin
               phase_d = PH_OFF;
               cnt_d   = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_OFF;
         cnt_q   <= '0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
      end
   end

   assign phase_o = phase_q;
   assign cnt_o   = cnt_q;

endmodule

// File: rtl/bist_char_map.sv
module bist_char_map
   import selftest_pkg::*;
#(
   parameter int              DATA_W = 8,
   parameter logic [DATA_W-1:0] K_CODE = DATA_W'(COMMA_K28_5)
) (
   input  phase_e            phase_i,
   input  logic [DATA_W-1:0] count_i,
   output logic [DATA_W-1:0] char_o,
   output logic              kflag_o,
   output logic              active_o
);

   always_comb begin
      active_o = (phase_i != PH_OFF);
      kflag_o  = (phase_i == PH_SYNC) || (phase_i == PH_IDLE);
      if (kflag_o)
         char_o = K_CODE;
      else if (phase_i == PH_DATA)
         char_o = count_i;
      else
         char_o = '0;
   end

endmodule

// File: rtl/bist_out_stage.sv
module bist_out_stage #(
   parameter int W          = 10,
   parameter bit REGISTERED = 1'b0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (REGISTERED) begin : g_reg
         logic [W-1:0] q_r;
         always_ff @(posedge clk) begin
            if (rst) q_r <= '0;
            else     q_r <= d_i;
         end
         assign q_o = q_r;
      end else begin : g_pass
         logic unused_clk;
         assign unused_clk = clk ^ rst;
         assign q_o = d_i;
      end
   endgenerate

endmodule

// File: rtl/selftest_pattern_gen.sv
module selftest_pattern_gen
   import selftest_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int SYNC_LEN  = 16,
   parameter int FRAME_LEN = 256,
   parameter int IDLE_LEN  = 3,
   parameter bit OUT_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              test_en,
   output logic [DATA_W-1:0] char_o,
   output logic              kflag_o,
   output logic              active_o
);

   localparam int LEN_MAX_A = (SYNC_LEN > FRAME_LEN) ? SYNC_LEN : FRAME_LEN;
   localparam int LEN_MAX   = (LEN_MAX_A > IDLE_LEN) ? LEN_MAX_A : IDLE_LEN;
   localparam int LEN_BITS  = (LEN_MAX > 1) ? $clog2(LEN_MAX) : 1;
   localparam int CNT_W     = (LEN_BITS > DATA_W) ? LEN_BITS : DATA_W;
   localparam int BUS_W     = DATA_W + 2;

   generate
      if (DATA_W < 8) begin : g_chk_width
         $error("DATA_W must hold a K28.5 code");
      end
      if (FRAME_LEN < 1 || FRAME_LEN > (1 << DATA_W)) begin : g_chk_frame
         $error("FRAME_LEN must lie in 1 .. 2**DATA_W");
      end
      if (SYNC_LEN < 1 || IDLE_LEN < 1) begin : g_chk_runs
         $error("SYNC_LEN and IDLE_LEN must be at least 1");
      end
   endgenerate

   phase_e            phase;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] map_char;
   logic              map_k;
   logic              map_act;
   logic [BUS_W-1:0]  bus_q;

   bist_phase_seq #(
      .SYNC_LEN (SYNC_LEN),
      .FRAME_LEN(FRAME_LEN),
      .IDLE_LEN (IDLE_LEN),
      .CNT_W    (CNT_W)
   ) u_seq (
      .clk    (clk),
      .rst    (rst),
      .enable (test_en),
      .phase_o(phase),
      .cnt_o  (cnt)
   );

   bist_char_map #(
      .DATA_W(DATA_W),
      .K_CODE(DATA_W'(COMMA_K28_5))
   ) u_map (
      .phase_i (phase),
      .count_i (cnt[DATA_W-1:0]),
      .char_o  (map_char),
      .kflag_o (map_k),
      .active_o(map_act)
   );

   bist_out_stage #(
      .W         (BUS_W),
      .REGISTERED(OUT_REG)
   ) u_out (
      .clk(clk),
      .rst(rst),
      .d_i({map_act, map_k, map_char}),
      .q_o(bus_q)
   );

   generate
      if (CNT_W > DATA_W) begin : g_hi_unused
         logic unused_hi;
         assign unused_hi = ^cnt[CNT_W-1:DATA_W];
      end
   endgenerate

   assign active_o = bus_q[BUS_W-1];
   assign kflag_o  = bus_q[BUS_W-2];
   assign char_o   = bus_q[DATA_W-1:0];

endmodule

// File: rtl/selftest_pattern_gen_chk.sv
module selftest_pattern_gen_chk #(
   parameter int DATA_W    = 8,
   parameter int SYNC_LEN  = 16,
   parameter int FRAME_LEN = 256,
   parameter bit OUT_REG   = 1'b0
) (
   input logic              clk,
   input logic              rst,
   input logic              test_en,
   input logic [DATA_W-1:0] char_o,
   input logic              kflag_o,
   input logic              active_o
);

   localparam logic [DATA_W-1:0] KC   = DATA_W'(8'hBC);
   localparam logic [DATA_W-1:0] LAST = DATA_W'(FRAME_LEN - 1);
   localparam int RUN_W = $clog2(SYNC_LEN + 2);

   logic [RUN_W-1:0] k_run;

   always_ff @(posedge clk) begin
      if (rst || !(active_o && kflag_o))
         k_run <= '0;
      else if (k_run != RUN_W'(SYNC_LEN + 1))
         k_run <= k_run + 1'b1;
   end

   assert_reset_clears_R1: assert property (@(posedge clk)
      rst |=> !active_o);

   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
      !active_o |-> (char_o == '0 && !kflag_o));

   assert_sync_first_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(active_o) |-> (kflag_o && char_o == KC));

   assert_krun_bound_R3: assert property (@(posedge clk) disable iff (rst)
      (active_o && kflag_o) |-> (k_run < RUN_W'(SYNC_LEN)));

   assert_data_step_R4: assert property (@(posedge clk) disable iff (rst)
      (active_o && !kflag_o && char_o != LAST) |=>
         (!active_o || (!kflag_o && char_o == $past(char_o) + 1'b1)));

   assert_frame_wrap_R5: assert property (@(posedge clk) disable iff (rst)
      (active_o && !kflag_o && char_o == LAST) |=>
         (!active_o || (kflag_o && char_o == KC)));

   assert_restart_zero_R5: assert property (@(posedge clk) disable iff (rst)
      (active_o && !kflag_o && $past(active_o && kflag_o)) |-> (char_o == '0));

   assert_k_code_R6: assert property (@(posedge clk) disable iff (rst)
      (active_o && kflag_o) |-> (char_o == KC));

   generate
      if (OUT_REG) begin : g_lat1
         logic en_d;
         always_ff @(posedge clk) en_d <= rst ? 1'b1 : test_en;
         assert_enable_drop_R7: assert property (@(posedge clk) disable iff (rst)
            !en_d |=> !active_o);
      end else begin : g_lat0
         assert_enable_drop_R7: assert property (@(posedge clk) disable iff (rst)
            !test_en |=> !active_o);
      end
   endgenerate

endmodule

bind selftest_pattern_gen selftest_pattern_gen_chk #(
   .DATA_W   (DATA_W),
   .SYNC_LEN (SYNC_LEN),
   .FRAME_LEN(FRAME_LEN),
   .OUT_REG  (OUT_REG)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .test_en (test_en),
   .char_o  (char_o),
   .kflag_o (kflag_o),
   .active_o(active_o)
);

// File: tb/selftest_pattern_gen_bench.sv
module selftest_pattern_gen_bench;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       test_en = 1'b0;
   logic [7:0] char_o;
   logic       kflag_o;
   logic       active_o;

   always #4 clk = ~clk;

   selftest_pattern_gen u_selftest_pattern_gen (
      .clk     (clk),
      .rst     (rst),
      .test_en (test_en),
      .char_o  (char_o),
      .kflag_o (kflag_o),
      .active_o(active_o)
   );

   int    checks   = 0;
   int    failures = 0;
   bit    done     = 1'b0;
   logic [9:0] exp_q[$];
   string      tag_q[$];

   int pos     = 0;
   bit reentry = 1'b0;
   bit was_on  = 1'b0;

   // Expected character at position p counted from the enabling edge.
   function automatic logic [9:0] expect_at(input int p, output string tag);
      int q;
      if (p < 16) begin
         tag = "R3 R6";
         return {1'b1, 1'b1, 8'hBC};
      end
      q = (p - 16) % 259;
      if (q < 256) begin
         tag = "R4 R8";
         return {1'b1, 1'b0, 8'(q)};
      end
      tag = "R5 R6";
      return {1'b1, 1'b1, 8'hBC};
   endfunction

   task automatic step(input logic en_v, input logic rst_v);
      string      t;
      logic [9:0] e;
      @(negedge clk);
      rst     = rst_v;
      test_en = en_v;
      if (rst_v) begin
         e = '0; t = "R1"; pos = 0; was_on = 1'b0; reentry = 1'b0;
      end else if (!en_v) begin
         e = '0; t = was_on ? "R7 R2" : "R2";
         if (was_on) reentry = 1'b1;
         pos = 0; was_on = 1'b0;
      end else begin
         e = expect_at(pos, t);
         if (reentry && pos < 16) t = "R7 R3";
         if (pos >= 16) reentry = 1'b0;
         pos++;
         was_on = 1'b1;
      end
      exp_q.push_back(e);
      tag_q.push_back(t);
   endtask

   task automatic run(input logic en_v, input logic rst_v, input int n);
      for (int i = 0; i < n; i++) step(en_v, rst_v);
   endtask

   // Monitor: compares each output sampled after the edge that produced it.
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            logic [9:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if ({active_o, kflag_o, char_o} !== e) begin
               failures++;
               $display("FAIL %s: got act=%b k=%b ch=%h, expected act=%b k=%b ch=%h",
                        t, active_o, kflag_o, char_o, e[9], e[8], e[7:0]);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      run(1'b0, 1'b1, 3);          // R1 reset state
      run(1'b0, 1'b0, 5);          // R2 quiet while disabled
      run(1'b1, 1'b0, 16 + 259*2 + 20); // R3 burst, R4 data, R5 two frame wraps
      run(1'b0, 1'b0, 3);          // R7 drop mid data
      run(1'b1, 1'b0, 40);         // R7 restart with full burst
      run(1'b1, 1'b0, 0);
      run(1'b0, 1'b0, 2);
      run(1'b1, 1'b0, 6);          // R7 drop in the burst
      run(1'b0, 1'b0, 1);
      run(1'b1, 1'b0, 30);         // R7 full burst again
      run(1'b1, 1'b1, 2);          // R1 reset mid run
      run(1'b1, 1'b0, 20);         // R3 burst after reset
      run(1'b0, 1'b0, 3);
      @(posedge clk);
      @(posedge clk);
      #3;
      if (exp_q.size() != 0) begin
         failures++;
         $display("FAIL scoreboard: got %0d pending, expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule